// File: doc/BRIEF.md
# ATM receive cell processor

This block sits between a line framer and a receive cell FIFO. It takes a stream of octets that has no cell boundaries and finds the boundaries itself. It does this by checking each header error control (HEC) octet against the four octets in front of it. Once the cell boundaries are held, each cell header goes through three steps. First the block verifies the header, correcting a single-bit error where allowed. Then it optionally drops idle cells. Then it optionally filters the cell against a configurable header pattern. The 48 payload octets are descrambled, and each surviving cell leaves the block as 53 octets, with a start-of-cell flag on the first octet.

Both streams use a valid/ready handshake. The framer stream is accepted one octet per cycle while `in_ready_o` is high. A transfer happens on a rising edge where valid and ready are both high. While a cell is being handed out, `in_ready_o` stays low and the framer must hold its octet. On the output side, once `out_valid_o` rises, the block keeps `out_data_o` and `out_soc_o` steady until `out_ready_i` takes the octet. The configuration inputs are sampled when a cell's HEC octet is accepted, so they may change between cells.

Top module: `atm_rx_cell_proc`

## Requirements
- R1: In the search state, every accepted octet is checked as a possible HEC for the four octets before it. A check passes when the CRC-8 (generator x^8+x^2+x+1, zero start, header bits most significant first), XORed with 0x55, equals that octet. The first pass makes that octet cell position 5 and enters the trial state.
- R2: In the trial state, seven further consecutive passing HEC checks, one per cell, lead to the locked state. Any failing check returns the block to the search state. Only cells whose HEC is checked in the locked state can be delivered, so `sync_o` is low until the eighth passing cell.
- R3: In the locked state, seven consecutive cells whose HEC is neither clean nor corrected return the block to the search state. A clean or corrected HEC resets this run.
- R4: In the locked state while in correction mode, a cell with exactly one flipped bit in its five header octets is repaired and delivered with the corrected header and HEC. The block then enters detection mode.
- R5: In detection mode, any HEC error is left uncorrected. A multi-bit error is likewise left uncorrected in either mode. Such a cell is dropped when `cfg_drop_err_i` is 1 and is otherwise delivered unchanged. Only a clean HEC restores correction mode.
- R6: A cell whose header is 0x00000001 is an idle cell and is dropped when `cfg_drop_idle_i` is 1.
- R7: With `cfg_filt_en_i` set, a header matches when ((header XOR `cfg_hdr_pat_i`) AND `cfg_hdr_mask_i`) is zero. When `cfg_filt_pass_i` is 1, only matching cells are kept. When it is 0, matching cells are dropped.
- R8: Payload octets are descrambled with the self-synchronising x^43+1 rule, most significant bit first. The descrambler state advances only on payload octets of aligned cells, so the original payload is restored.
- R9: A delivered cell is 53 output octets: header octets 1 to 4, the HEC, then 48 payload octets. `out_soc_o` is set on the first octet only. An offered octet stays stable until it is taken.
- R10: `in_ready_o` is low while a cell is being delivered.
- R11: `ev_corr_o` pulses for one cycle per corrected cell. `ev_drop_o` pulses for one cycle per cell dropped in the locked state. Each pulse appears in the cycle after the HEC octet is accepted.
- R12: After reset the block is in the search state, with `sync_o` low, `out_valid_o` low, `in_ready_o` high and no event pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Framer octet valid |
| in_ready_o | output | 1 | Block can accept an octet |
| in_data_i | input | 8 | Framer octet |
| out_valid_o | output | 1 | Cell octet offered |
| out_ready_i | input | 1 | FIFO takes the octet |
| out_data_o | output | 8 | Cell octet |
| out_soc_o | output | 1 | First octet of a cell |
| cfg_drop_err_i | input | 1 | Drop cells with uncorrected HEC errors |
| cfg_drop_idle_i | input | 1 | Drop idle cells |
| cfg_filt_en_i | input | 1 | Enable header filter |
| cfg_filt_pass_i | input | 1 | 1: keep matches, 0: drop matches |
| cfg_hdr_pat_i | input | 32 | Header compare pattern |
| cfg_hdr_mask_i | input | 32 | Header compare mask |
| sync_o | output | 1 | Locked to cell boundaries |
| ev_corr_o | output | 1 | Header corrected pulse |
| ev_drop_o | output | 1 | Cell dropped pulse |

## Verification
The assertions take three things for granted. The FIFO side may stall at any time. The framer keeps its octet steady while `in_ready_o` is low. Configuration changes only between HEC octets. The stimulus follows these assumptions: it drives octets only through a handshake task, toggles `out_ready_i` from a pseudo-random pattern, and changes configuration only between whole cells. The first header after each reset is chosen so that no false HEC match can arise while the header window is still filling. Error patterns are single flips or flips of two bits, so correction and detection outcomes never depend on aliasing.

// File: rtl/atm_rx_pkg.sv
package atm_rx_pkg;
  localparam int CELL_LEN = 53;
  localparam int HDR_LEN  = 5;
  localparam int PAY_LEN  = CELL_LEN - HDR_LEN;
  localparam logic [7:0]  HEC_COSET = 8'h55;
  localparam logic [31:0] IDLE_HDR  = 32'h0000_0001;

  typedef enum logic [1:0] {DL_HUNT, DL_PRESYNC, DL_SYNC} dl_state_t;

  // CRC-8, generator x^8+x^2+x+1, zero start, MSB first over the header
  function automatic logic [7:0] crc8_hdr(input logic [31:0] d);
    logic [7:0] c;
    logic fb;
    c = '0;
    for (int i = 31; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction
endpackage

// File: rtl/rcp_hec_check.sv
module rcp_hec_check
  import atm_rx_pkg::*;
(
  input  logic [39:0] word_i,
  output logic        clean_o,
  output logic        single_o,
  output logic [39:0] fixed_o
);
  logic [7:0] syn;

  always_comb begin
    syn      = crc8_hdr(word_i[39:8]) ^ word_i[7:0] ^ HEC_COSET;
    clean_o  = (syn == 8'h00);
    single_o = 1'b0;
    fixed_o  = word_i;
    if (!clean_o) begin
      // error inside the HEC octet itself
      if ($onehot(syn)) begin
        single_o      = 1'b1;
        fixed_o[7:0]  = word_i[7:0] ^ syn;
      end
      // error in one of the 32 header bits: syndrome equals CRC of that bit
      for (int i = 0; i < 32; i++) begin
        if (crc8_hdr(32'd1 << i) == syn) begin
          single_o       = 1'b1;
          fixed_o[8 + i] = ~word_i[8 + i];
        end
      end
    end
  end
endmodule

// File: rtl/rcp_delin.sv
module rcp_delin
  import atm_rx_pkg::*;
#(
  parameter int SYNC_CNT = 7,
  parameter int LOSS_CNT = 7
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step_i,
  input  logic      clean_i,
  input  logic      single_i,
  output dl_state_t state_o,
  output logic [5:0] pos_o,
  output logic      eval_o,
  output logic      fix_o,
  output logic      hec_ok_o
);
  localparam int MAXC = (SYNC_CNT > LOSS_CNT) ? SYNC_CNT : LOSS_CNT;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [5:0] LAST_POS = 6'(CELL_LEN - 1);
  localparam logic [5:0] HEC_POS  = 6'(HDR_LEN - 1);

  dl_state_t state_q;
  logic [5:0]    pos_q;
  logic [CW-1:0] cnt_q;
  logic          corr_mode_q;

  assign eval_o   = step_i && (state_q == DL_HUNT || pos_q == HEC_POS);
  assign fix_o    = eval_o && state_q == DL_SYNC && corr_mode_q && single_i;
  assign hec_ok_o = clean_i || fix_o;
  assign state_o  = state_q;
  assign pos_o    = pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= DL_HUNT;
      pos_q       <= '0;
      cnt_q       <= '0;
      corr_mode_q <= 1'b1;
    end else if (step_i) begin
      if (state_q != DL_HUNT)
        pos_q <= (pos_q == LAST_POS) ? 6'd0 : pos_q + 6'd1;
      if (eval_o) begin
        unique case (state_q)
          DL_HUNT: if (clean_i) begin
            state_q <= DL_PRESYNC;
            pos_q   <= 6'(HDR_LEN);
            cnt_q   <= '0;
          end
          DL_PRESYNC: if (!clean_i) begin
            state_q <= DL_HUNT;
          end else if (cnt_q == CW'(SYNC_CNT - 1)) begin
            state_q     <= DL_SYNC;
            cnt_q       <= '0;
            corr_mode_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
          default: begin
            corr_mode_q <= clean_i;
            if (hec_ok_o) cnt_q <= '0;
            else if (cnt_q == CW'(LOSS_CNT - 1)) begin
              state_q <= DL_HUNT;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
        endcase
      end
    end
  end

  a_r1_hunt_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_o && state_q == DL_HUNT && clean_i) |=> (state_q == DL_PRESYNC && pos_q == 6'(HDR_LEN)));
  a_r2_sync_via_presync: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DL_SYNC && $past(state_q) != DL_SYNC) |-> $past(state_q) == DL_PRESYNC);
  a_r2_presync_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_o && state_q == DL_PRESYNC && !clean_i) |=> state_q == DL_HUNT);
endmodule

// File: rtl/rcp_descram.sv
module rcp_descram #(
  parameter int LEN = 43
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [7:0] data_i,
  output logic [7:0] data_o
);
  logic [LEN-1:0] hist_q, hist_d;

  always_comb begin
    hist_d = hist_q;
    for (int j = 7; j >= 0; j--) begin
      data_o[j] = data_i[j] ^ hist_d[LEN-1];
      hist_d    = {hist_d[LEN-2:0], data_i[j]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hist_q <= '0;
    else if (en_i) hist_q <= hist_d;
  end
endmodule

// File: rtl/atm_rx_cell_proc.sv
module atm_rx_cell_proc
  import atm_rx_pkg::*;
#(
  parameter int SYNC_CNT = 7,
  parameter int LOSS_CNT = 7,
  parameter int SCR_LEN  = 43
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  logic [7:0]  in_data_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [7:0]  out_data_o,
  output logic        out_soc_o,
  input  logic        cfg_drop_err_i,
  input  logic        cfg_drop_idle_i,
  input  logic        cfg_filt_en_i,
  input  logic        cfg_filt_pass_i,
  input  logic [31:0] cfg_hdr_pat_i,
  input  logic [31:0] cfg_hdr_mask_i,
  output logic        sync_o,
  output logic        ev_corr_o,
  output logic        ev_drop_o
);
  localparam logic [5:0] LAST_POS  = 6'(CELL_LEN - 1);
  localparam logic [5:0] FIRST_PAY = 6'(HDR_LEN);

  logic [31:0] win_q;
  logic [39:0] win_nx, fixed;
  logic        clean, single, step, eval, fix, hec_ok;
  dl_state_t   state;
  logic [5:0]  pos;
  logic        pay_byte, sync_eval;
  logic [7:0]  plain;
  logic [39:0] hdr_use;
  logic        is_idle, hdr_match, keep_d, keep_q;
  logic        drain_q;
  logic [5:0]  ridx_q;
  logic        ev_corr_q, ev_drop_q;
  logic [7:0]  hdr_b   [HDR_LEN];
  logic [7:0]  pay_mem [PAY_LEN];

  assign in_ready_o = !drain_q;
  assign step       = in_valid_i && in_ready_o;
  assign win_nx     = {win_q, in_data_i};

  rcp_hec_check u_hec (
    .word_i  (win_nx),
    .clean_o (clean),
    .single_o(single),
    .fixed_o (fixed)
  );

  rcp_delin #(.SYNC_CNT(SYNC_CNT), .LOSS_CNT(LOSS_CNT)) u_dl (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (step),
    .clean_i (clean),
    .single_i(single),
    .state_o (state),
    .pos_o   (pos),
    .eval_o  (eval),
    .fix_o   (fix),
    .hec_ok_o(hec_ok)
  );

  assign pay_byte  = step && state != DL_HUNT && pos >= FIRST_PAY;
  assign sync_eval = eval && state == DL_SYNC;

  rcp_descram #(.LEN(SCR_LEN)) u_ds (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (pay_byte),
    .data_i(in_data_i),
    .data_o(plain)
  );

  // cell verdict at the HEC octet
  always_comb begin
    hdr_use   = fix ? fixed : win_nx;
    is_idle   = hdr_use[39:8] == IDLE_HDR;
    hdr_match = ((hdr_use[39:8] ^ cfg_hdr_pat_i) & cfg_hdr_mask_i) == 32'd0;
    keep_d    = !((!hec_ok && cfg_drop_err_i) ||
                  (is_idle && cfg_drop_idle_i) ||
                  (cfg_filt_en_i && (hdr_match ^ cfg_filt_pass_i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q     <= '0;
      keep_q    <= 1'b0;
      drain_q   <= 1'b0;
      ridx_q    <= '0;
      ev_corr_q <= 1'b0;
      ev_drop_q <= 1'b0;
    end else begin
      ev_corr_q <= sync_eval && fix;
      ev_drop_q <= sync_eval && !keep_d;
      if (step) win_q <= win_nx[31:0];
      if (eval) keep_q <= sync_eval && keep_d;
      if (step && state != DL_HUNT && pos == LAST_POS && keep_q) begin
        drain_q <= 1'b1;
        ridx_q  <= '0;
      end else if (drain_q && out_ready_i) begin
        if (ridx_q == LAST_POS) drain_q <= 1'b0;
        else ridx_q <= ridx_q + 6'd1;
      end
    end
  end

  // cell storage, no reset needed
  always_ff @(posedge clk) begin
    if (sync_eval)
      for (int k = 0; k < HDR_LEN; k++) hdr_b[k] <= hdr_use[39 - 8*k -: 8];
    if (pay_byte) pay_mem[pos - FIRST_PAY] <= plain;
  end

  always_comb begin
    if (ridx_q < FIRST_PAY) out_data_o = hdr_b[ridx_q[2:0]];
    else                    out_data_o = pay_mem[ridx_q - FIRST_PAY];
  end

  assign out_valid_o = drain_q;
  assign out_soc_o   = drain_q && ridx_q == 6'd0;
  assign sync_o      = state == DL_SYNC;
  assign ev_corr_o   = ev_corr_q;
  assign ev_drop_o   = ev_drop_q;

  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_soc_o)));
  a_r11_corr_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ev_corr_o |-> $past(sync_o));
  a_r11_drop_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop_o |-> $past(sync_o));
endmodule

// File: tb/sim_atm_rx_cell_proc.sv
`timescale 1ns/1ps
module sim_atm_rx_cell_proc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = 8'h00;
  logic out_valid, out_ready = 1'b0, out_soc;
  logic [7:0] out_data;
  logic drop_err = 1'b1, drop_idle = 1'b1, filt_en = 1'b0, filt_pass = 1'b1;
  logic [31:0] hdr_pat = '0, hdr_mask = '0;
  logic sync_o, ev_corr, ev_drop;

  int checks = 0, errors = 0;
  int got_corr = 0, got_drop = 0;
  bit r10_bad = 1'b0;
  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic [42:0] shist = '0;

  always #2.5 clk = ~clk;

  atm_rx_cell_proc u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_data_o(out_data), .out_soc_o(out_soc),
    .cfg_drop_err_i(drop_err), .cfg_drop_idle_i(drop_idle),
    .cfg_filt_en_i(filt_en), .cfg_filt_pass_i(filt_pass),
    .cfg_hdr_pat_i(hdr_pat), .cfg_hdr_mask_i(hdr_mask),
    .sync_o(sync_o), .ev_corr_o(ev_corr), .ev_drop_o(ev_drop)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [7:0] c = 8'h00;
    for (int b = 3; b >= 0; b--) begin
      c ^= h[8*b +: 8];
      for (int n = 0; n < 8; n++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c ^ 8'h55;
  endfunction

  function automatic logic [7:0] plain_of(input int seed, input int i);
    if (seed == 0)   return 8'h00;
    if (seed == 255) return 8'hFF;
    return 8'((seed * 37 + i * 11 + i * i) & 255);
  endfunction

  // caller is at a falling edge; returns at the falling edge after acceptance
  task automatic put_byte(input logic [7:0] b);
    bit r;
    in_valid = 1'b1;
    in_data  = b;
    forever begin
      r = in_ready;
      @(posedge clk);
      @(negedge clk);
      if (r) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic send_cell(input logic [31:0] hdr, input logic [39:0] emask, input int seed,
                           input bit deliver, input bit fixd, input string tag);
    logic [39:0] good_w, tx_w, exp_w;
    logic [7:0] p, s;
    good_w = {hdr, ref_hec(hdr)};
    tx_w   = good_w ^ emask;
    exp_w  = fixd ? good_w : tx_w;
    if (deliver) begin
      for (int k = 0; k < 5; k++) begin
        exp_q.push_back({k == 0, exp_w[39 - 8*k -: 8]});
        tag_q.push_back(tag);
      end
      for (int i = 0; i < 48; i++) begin
        exp_q.push_back({1'b0, plain_of(seed, i)});
        tag_q.push_back("R8");
      end
    end
    for (int k = 0; k < 5; k++) put_byte(tx_w[39 - 8*k -: 8]);
    for (int i = 0; i < 48; i++) begin
      p = plain_of(seed, i);
      for (int j = 7; j >= 0; j--) begin
        s[j]  = p[j] ^ shist[42];
        shist = {shist[41:0], s[j]};
      end
      put_byte(s);
    end
  endtask

  task automatic restart();
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic warmup();
    for (int n = 0; n < 8; n++) begin
      send_cell(32'h0010_0020, 40'd0, n + 1, 1'b0, 1'b0, "R2");
      if (n == 6) chk(sync_o == 1'b0, "R2 lock needs seven further HECs", sync_o, 0);
    end
    chk(sync_o == 1'b1, "R1 R2 lock after eighth clean cell", sync_o, 1);
  endtask

  // monitor / scoreboard
  initial begin
    logic [15:0] rng = 16'hACE1;
    logic [8:0] item;
    string t;
    forever begin
      @(negedge clk);
      if (ev_corr) got_corr++;
      if (ev_drop) got_drop++;
      if (out_valid && in_ready) r10_bad = 1'b1;
      rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
      out_ready = rng[0] | rng[3];
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 R6 R7 unexpected cell octet", {23'd0, out_soc, out_data}, 32'h0);
        end else begin
          item = exp_q.pop_front();
          t    = tag_q.pop_front();
          chk({out_soc, out_data} == item, t, {23'd0, out_soc, out_data}, {23'd0, item});
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(sync_o == 1'b0 && out_valid == 1'b0 && in_ready == 1'b1 && !ev_corr && !ev_drop,
        "R12 reset state", {sync_o, out_valid, in_ready, ev_corr, ev_drop}, 5'b00100);
    rst_n = 1'b1;
    @(negedge clk);
    warmup();

    send_cell(32'h1234_5670, 40'd0, 11, 1'b1, 1'b0, "R9 clean cell");
    send_cell(32'h0A0B_0C00, 40'd1 << 21, 12, 1'b1, 1'b1, "R4 header bit corrected");
    send_cell(32'h0A0B_0C10, 40'd1 << 30, 13, 1'b0, 1'b0, "R5 detection mode drop");
    send_cell(32'h0202_0200, 40'd0, 14, 1'b1, 1'b0, "R5 clean restores correction");
    send_cell(32'h0303_0300, 40'd1 << 3, 15, 1'b1, 1'b1, "R4 HEC bit corrected");
    send_cell(32'h0404_0400, 40'd0, 16, 1'b1, 1'b0, "R9 clean cell");
    drop_err = 1'b0;
    send_cell(32'h0505_0500, (40'd1 << 20) | (40'd1 << 21), 17, 1'b1, 1'b0, "R5 multi-bit passed unchanged");
    send_cell(32'h0000_0001, 40'd0, 18, 1'b0, 1'b0, "R6 idle dropped");
    drop_idle = 1'b0;
    send_cell(32'h0000_0001, 40'd0, 19, 1'b1, 1'b0, "R6 idle kept");

    filt_en = 1'b1; filt_pass = 1'b1;
    hdr_pat = 32'h00AB_0000; hdr_mask = 32'h00FF_0000;
    send_cell(32'h00AB_1230, 40'd0, 20, 1'b1, 1'b0, "R7 pass mode match kept");
    send_cell(32'h00CD_1230, 40'd0, 21, 1'b0, 1'b0, "R7 pass mode miss dropped");
    filt_pass = 1'b0;
    send_cell(32'h00AB_1230, 40'd0, 22, 1'b0, 1'b0, "R7 block mode match dropped");
    send_cell(32'h00CD_1230, 40'd0, 23, 1'b1, 1'b0, "R7 block mode miss kept");

    filt_en = 1'b0; drop_err = 1'b1;
    for (int n = 0; n < 7; n++) begin
      send_cell(32'h0606_0600, 40'h03, 30 + n, 1'b0, 1'b0, "R3");
      if (n == 5) chk(sync_o == 1'b1, "R3 still locked after six bad cells", sync_o, 1);
    end
    chk(sync_o == 1'b0, "R3 lock lost after seven bad cells", sync_o, 0);

    while (exp_q.size() != 0) @(negedge clk);
    restart();
    drop_idle = 1'b1;
    warmup();
    send_cell(32'h0102_0300, 40'd0, 0, 1'b1, 1'b0, "R8 zero payload");
    send_cell(32'h0F0E_0D00, 40'd0, 255, 1'b1, 1'b0, "R8 ones payload");
    send_cell(32'h0708_0900, 40'd0, 77, 1'b1, 1'b0, "R9 after relock");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(got_corr == 2, "R11 corrected pulses", got_corr, 2);
    chk(got_drop == 11, "R11 drop pulses", got_drop, 11);
    chk(!r10_bad, "R10 input stalled during delivery", r10_bad, 0);
    chk(exp_q.size() == 0, "R9 all expected octets seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule